// File: doc/BRIEF.md
# Three-Wire Transceiver Configuration Slave

This block receives configuration words from a controller over a three-wire serial bus (bus clock, serial data, active-low enable) and holds the decoded settings of a radio transceiver. The bus pins are asynchronous to the block's system clock. Each pin passes through a synchronizer, and the block finds the bus edges by comparing successive synchronized samples.

When enable falls, the shift register is cleared. While enable stays low, each rising bus clock edge shifts one data bit in, most significant bit first. Only the last 25 bits are kept. When enable rises, the held word becomes active, and the block emits a one-cycle `updated_o` strobe together with the new field values.

A plain 16-bit word sets the mode, ramp level, deviation scaling, reference select, main-counter code and swallow count. A 25-bit word that begins with a fixed 9-bit prefix and carries receive mode also turns on receive clock recovery.

Top module: `tw_cfg_slave`

## Requirements
- R1: While reset is asserted and after it is released, every field output and `updated_o` read zero.
- R2: Bits are taken on rising bus clock edges while enable is low, most significant bit first. In the latched word, bits 15..14 are the mode, 13..12 the ramp level, 11..9 the deviation code, bit 7 the reference select, 6..5 the main-counter code and 4..0 the swallow count. Bit 8 is ignored.
- R3: Field outputs do not change while a word is being shifted in. They change only in the cycle `updated_o` is high, which follows a rise of enable.
- R4: Bits beyond the last 25 shifted in a word are discarded. The pulse count is not checked. A word shorter than 25 bits reads as zeros in its missing upper positions.
- R5: `clk_rec_en_o` becomes 1 when bits 24..16 of the latched word equal 101000000 and bits 15..14 equal 00.
- R6: Any latched word that fails the test of R5 clears `clk_rec_en_o`. This covers a 16-bit word, a prefix combined with mode 01, and a wrong prefix.
- R7: `dev_pct_o` equals 60 + 10 × deviation code, giving 60 for code 000 up to 130 for code 111.
- R8: `updated_o` is high for exactly one cycle per word. With the default two synchronizer stages, it appears on the third system clock edge after enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sck_i | input | 1 | Serial bus clock (asynchronous) |
| cfg_sdi_i | input | 1 | Serial bus data (asynchronous) |
| cfg_sen_n_i | input | 1 | Serial bus enable, active low (asynchronous) |
| mode_o | output | 2 | Mode field, bits 15..14 |
| ramp_lvl_o | output | 2 | Ramp level field, bits 13..12 |
| dev_code_o | output | 3 | Deviation scaling code, bits 11..9 |
| dev_pct_o | output | 8 | Deviation scaling in percent |
| ref_sel_o | output | 1 | Reference select, bit 7 |
| main_code_o | output | 2 | Main-counter code, bits 6..5 |
| swallow_o | output | 5 | Swallow count, bits 4..0 |
| clk_rec_en_o | output | 1 | Receive clock recovery enable |
| updated_o | output | 1 | One-cycle strobe when a word is latched |

## Verification
A fault in the shift register reaches the outputs at the next enable rise, three cycles after enable rises. It appears as shifted or stale field bits, or as a wrong clock-recovery flag when the upper bits are not cleared between words. A fault in edge detection shows as a strobe that is missing, late, doubled, or raised while enable is still low. Each word the bench sends is predicted from a bit-level model and compared at the strobe. Held outputs are also compared halfway through every word.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

    localparam int SHORT_LEN  = 16;
    localparam int LONG_LEN   = 25;
    localparam int PREFIX_LEN = LONG_LEN - SHORT_LEN;
    localparam logic [PREFIX_LEN-1:0] REC_PREFIX = 9'b101000000;

    localparam logic [1:0] MODE_RX_REC = 2'b00;

    // field positions inside the latched word
    localparam int MODE_LO  = 14;
    localparam int RAMP_LO  = 12;
    localparam int DEV_LO   = 9;
    localparam int REF_POS  = 7;
    localparam int MAIN_LO  = 5;
    localparam int SW_LO    = 0;

    localparam int DEV_W    = 3;
    localparam int SW_W     = 5;
    localparam int PCT_W    = 8;
    localparam int PCT_BASE = 60;
    localparam int PCT_STEP = 10;

    // bus pin indices inside the synchronizer vector
    localparam int BUS_N   = 3;
    localparam int BUS_SCK = 0;
    localparam int BUS_SDI = 1;
    localparam int BUS_SEN = 2;

    typedef struct packed {
        logic [1:0]       mode;
        logic [1:0]       ramp;
        logic [DEV_W-1:0] dev;
        logic [PCT_W-1:0] pct;
        logic             ref_sel;
        logic [1:0]       main_code;
        logic [SW_W-1:0]  swallow;
        logic             rec_en;
    } cfg_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = async_i;
        for (int k = 1; k < DEPTH; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= RST_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                shift_i,
    input  logic                bit_i,
    output logic [LONG_LEN-1:0] word_o
);

    logic [LONG_LEN-1:0] shreg_d, shreg_q;

    always_comb begin
        shreg_d = shreg_q;
        if (start_i) begin
            shreg_d = '0;
        end else if (shift_i) begin
            shreg_d = {shreg_q[LONG_LEN-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= shreg_d;
    end

    assign word_o = shreg_q;

endmodule

// File: rtl/tw_decode.sv
module tw_decode
    import tw_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_i,
    input  logic [LONG_LEN-1:0] word_i,
    output cfg_t                cfg_o,
    output logic                updated_o
);

    typedef struct packed {
        cfg_t cfg;
        logic upd;
    } dec_state_t;

    dec_state_t st_d, st_q;
    cfg_t       next_cfg;
    logic       unused_bit8;

    assign unused_bit8 = word_i[8];

    always_comb begin
        next_cfg.mode      = word_i[MODE_LO +: 2];
        next_cfg.ramp      = word_i[RAMP_LO +: 2];
        next_cfg.dev       = word_i[DEV_LO +: DEV_W];
        next_cfg.pct       = PCT_W'(PCT_BASE + PCT_STEP * int'(word_i[DEV_LO +: DEV_W]));
        next_cfg.ref_sel   = word_i[REF_POS];
        next_cfg.main_code = word_i[MAIN_LO +: 2];
        next_cfg.swallow   = word_i[SW_LO +: SW_W];
        next_cfg.rec_en    = (word_i[LONG_LEN-1:SHORT_LEN] == REC_PREFIX) &&
                             (word_i[MODE_LO +: 2] == MODE_RX_REC);

        st_d     = st_q;
        st_d.upd = 1'b0;
        if (latch_i) begin
            st_d.cfg = next_cfg;
            st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o     = st_q.cfg;
    assign updated_o = st_q.upd;

endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
    import tw_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sck_i,
    input  logic             cfg_sdi_i,
    input  logic             cfg_sen_n_i,
    output logic [1:0]       mode_o,
    output logic [1:0]       ramp_lvl_o,
    output logic [DEV_W-1:0] dev_code_o,
    output logic [PCT_W-1:0] dev_pct_o,
    output logic             ref_sel_o,
    output logic [1:0]       main_code_o,
    output logic [SW_W-1:0]  swallow_o,
    output logic             clk_rec_en_o,
    output logic             updated_o
);

    localparam logic [BUS_N-1:0] BUS_IDLE = BUS_N'(1) << BUS_SEN;

    logic [BUS_N-1:0]    bus_raw, bus_sync, bus_prev;
    logic                sck_rise, sen_fall, sen_rise, sen_low;
    logic                unused_sdi_prev;
    logic [LONG_LEN-1:0] word;
    cfg_t                cfg;

    always_comb begin
        bus_raw          = '0;
        bus_raw[BUS_SCK] = cfg_sck_i;
        bus_raw[BUS_SDI] = cfg_sdi_i;
        bus_raw[BUS_SEN] = cfg_sen_n_i;
    end

    tw_sync #(
        .WIDTH   (BUS_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_raw),
        .sync_o  (bus_sync),
        .prev_o  (bus_prev)
    );

    assign sck_rise        = bus_sync[BUS_SCK] & ~bus_prev[BUS_SCK];
    assign sen_fall        = ~bus_sync[BUS_SEN] & bus_prev[BUS_SEN];
    assign sen_rise        = bus_sync[BUS_SEN] & ~bus_prev[BUS_SEN];
    assign sen_low         = ~bus_sync[BUS_SEN];
    assign unused_sdi_prev = bus_prev[BUS_SDI];

    tw_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sen_fall),
        .shift_i (sck_rise & sen_low),
        .bit_i   (bus_sync[BUS_SDI]),
        .word_o  (word)
    );

    tw_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (sen_rise),
        .word_i    (word),
        .cfg_o     (cfg),
        .updated_o (updated_o)
    );

    assign mode_o       = cfg.mode;
    assign ramp_lvl_o   = cfg.ramp;
    assign dev_code_o   = cfg.dev;
    assign dev_pct_o    = cfg.pct;
    assign ref_sel_o    = cfg.ref_sel;
    assign main_code_o  = cfg.main_code;
    assign swallow_o    = cfg.swallow;
    assign clk_rec_en_o = cfg.rec_en;

endmodule

// File: rtl/tw_cfg_slave_chk.sv
module tw_cfg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_sen_n_i,
    input logic [1:0] mode_o,
    input logic [1:0] ramp_lvl_o,
    input logic [2:0] dev_code_o,
    input logic [7:0] dev_pct_o,
    input logic       ref_sel_o,
    input logic [1:0] main_code_o,
    input logic [4:0] swallow_o,
    input logic       clk_rec_en_o,
    input logic       updated_o
);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        updated_o |=> !updated_o);

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !updated_o |-> $stable({mode_o, ramp_lvl_o, dev_code_o, dev_pct_o,
                                ref_sel_o, main_code_o, swallow_o, clk_rec_en_o}));

    assert_update_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        updated_o |-> cfg_sen_n_i);

    assert_rec_needs_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rec_en_o |-> (mode_o == 2'b00));

    assert_pct_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        updated_o |-> (dev_pct_o >= 8'd60 && dev_pct_o <= 8'd130 && (dev_pct_o % 8'd10) == 8'd0));

endmodule

bind tw_cfg_slave tw_cfg_slave_chk u_chk (.*);

// File: tb/tw_cfg_slave_test.sv
module tw_cfg_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sen_n = 1'b1;
    logic [1:0] mode_o, ramp_lvl_o, main_code_o;
    logic [2:0] dev_code_o;
    logic [7:0] dev_pct_o;
    logic       ref_sel_o, clk_rec_en_o, updated_o;
    logic [4:0] swallow_o;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q[$];
    logic [23:0] held = '0;
    logic        prev_upd = 1'b0;

    always #10 clk = ~clk;

    tw_cfg_slave uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sck_i(sck), .cfg_sdi_i(sdi), .cfg_sen_n_i(sen_n),
        .mode_o(mode_o), .ramp_lvl_o(ramp_lvl_o), .dev_code_o(dev_code_o),
        .dev_pct_o(dev_pct_o), .ref_sel_o(ref_sel_o), .main_code_o(main_code_o),
        .swallow_o(swallow_o), .clk_rec_en_o(clk_rec_en_o), .updated_o(updated_o)
    );

    function automatic logic [23:0] observed();
        return {mode_o, ramp_lvl_o, dev_code_o, dev_pct_o, ref_sel_o,
                main_code_o, swallow_o, clk_rec_en_o};
    endfunction

    function automatic logic [23:0] predict(input logic [24:0] w);
        logic [7:0] pct;
        logic       rec;
        pct = 8'(60 + 10 * int'(w[11:9]));
        rec = (w[24:16] == 9'b101000000) && (w[15:14] == 2'b00);
        return {w[15:14], w[13:12], w[11:9], pct, w[7], w[6:5], w[4:0], rec};
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] bits, input int n, input string req);
        logic [24:0] m;
        logic [23:0] e;
        int k;
        m = '0;
        k = 0;
        @(negedge clk);
        sen_n = 1'b0;
        wait_clk(5);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            m = {m[23:0], bits[i]};
            if (i == n / 2) check(observed() == held, "R3 hold mid-word", observed(), held);
        end
        wait_clk(3);
        e = predict(m);
        exp_q.push_back(e);
        sen_n = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (updated_o && k == 0) k = c;
        end
        check(k == 3, "R8 latency", 24'(k), 24'd3);
        held = e;
        check(observed() == e, req, observed(), e);
        wait_clk(12);
    endtask

    // monitor: compares each latched word against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_upd && updated_o)
                check(1'b0, "R8 strobe width", 24'd2, 24'd1);
            if (updated_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected update", observed(), held);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(observed() == e, "R2 scoreboard", observed(), e);
                end
            end
            prev_upd <= updated_o;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_clk(3);
        check(observed() == 24'd0 && !updated_o, "R1 in reset", observed(), 24'd0);
        rst_n = 1'b1;
        wait_clk(5);
        check(observed() == 24'd0 && !updated_o, "R1 after reset", observed(), 24'd0);

        // R2: transmit word, all fields distinct
        send_word(32'h0000_6BB3, 16, "R2 tx word");
        // R5: full 25-bit recovery word
        send_word({7'd0, 9'b101000000, 16'h3E7F}, 25, "R5 recovery word");
        // R6: plain 16-bit receive word clears recovery
        send_word(32'h0000_0025, 16, "R6 short clears");
        // R4: five extra leading ones are discarded, recovery still found
        send_word({2'b00, 5'b11111, 9'b101000000, 16'h0A41}, 30, "R4 extra leading bits");
        // R6: prefix with transmit mode
        send_word({7'd0, 9'b101000000, 16'h4A8C}, 25, "R6 prefix tx mode");
        // R6: wrong prefix
        send_word({7'd0, 9'b101000001, 16'h0012}, 25, "R6 bad prefix");
        // R4: short 8-bit word, upper positions read zero
        send_word(32'h0000_00D7, 8, "R4 short word");
        // R7: every deviation code
        for (int d = 0; d < 8; d++) begin
            send_word(32'h0000_4000 | (32'(d) << 9) | 32'h0000_0091, 16, "R7 deviation code");
        end
        wait_clk(10);
        check(exp_q.size() == 0, "R8 missing strobe", 24'(exp_q.size()), 24'd0);
        finish_run();
    end

endmodule